// File: doc/BRIEF.md
# NAND Flash Read Output Path

This block produces everything a NAND flash model drives back onto its data bus during reads. There are three sources: page data taken from the array through a combinational read port, the status byte, and the four-byte identification sequence. A command front end selects the source with single-cycle start pulses. On a sequential read start it also hands over the start column and a pending column offset.

A read strobe (`re_i`) registers one bus word into `rdata_o`. Sequential reads keep a column pointer and a count of remaining bytes. When the count is zero, the next strobe reloads the page from the current column plus the pending offset, and that same strobe returns the first word. The block can be built for an 8-bit or a 16-bit bus. On a 16-bit bus, status and ID bytes sit in the low lane and the high lane is zero. Ready/busy is always reported as ready, because operations here complete at once.

Top module: `nand_rd_path`

## Requirements
- R1: While reset is asserted, and right after it is released, `rdata_o` is 0, the block is in sequential-read mode with column 0, pending offset 0 and nothing buffered, so `arr_col_o` reads 0. `rb_o` is 1 at all times.
- R2: The status word has the following bits:
  - bit 0 is `stat_err_i`;
  - bits 4:1 are `stat_plane_i[3:0]`;
  - bit 5 is 0;
  - bit 6 is 1 (ready);
  - bit 7 equals `wp_ni` as sampled at the strobe edge.
- R3: After `cmd_status_i`, every strobe with `ce_ni` low returns the status word, and `arr_col_o` does not move.
- R4: After `cmd_id_i`, the first four strobes with `ce_ni` low return, in order:
  - `MAKER_CODE`;
  - `PART_CODE`;
  - `FILL_CODE`;
  - a tail byte: 0x15 for an 8-bit large-page build, 0x55 for a 16-bit large-page build, 0xC0 for a small-page build.

  Later strobes return 0 until a new command arrives.
- R5: With `BUS_BYTES`=2, status and ID bytes occupy bits 7:0 and bits 15:8 are 0.
- R6: In sequential mode, a strobe that finds no bytes remaining does three things:
  - it loads from start = column + pending offset, clamped to the end limit;
  - it clears the pending offset;
  - in that same strobe it returns the array word at the start column.
- R7: The loaded length in bytes is PAGE + PAGE/32 − start. When `spare_off_i` is 1 it is PAGE − start. It is 0 when start is at or past the limit. A strobe with no bytes left after loading returns 0.
- R8: A strobe while `ce_ni` is 1 returns 0 and advances nothing, though a reload it triggers still takes effect.
- R9: Each returned page word advances `arr_col_o` by `BUS_BYTES` and lowers the remaining count by `BUS_BYTES`, saturating at 0.
- R10: `rdata_o` takes its new value at the clock edge that samples `re_i` high, using `arr_data_i` for `arr_col_o` at that edge, and holds between strobes.
- R11: Any command pulse ends the previous mode. A strobe in the same cycle as a command pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_read_i | input | 1 | Start pulse: sequential read |
| cmd_status_i | input | 1 | Start pulse: status read |
| cmd_id_i | input | 1 | Start pulse: ID read |
| col_i | input | PAGE_W+2 | Start column for a sequential read |
| ofs_i | input | PAGE_W+2 | Pending column offset for a sequential read |
| re_i | input | 1 | Read strobe, one word per cycle high |
| ce_ni | input | 1 | Chip enable, active low |
| spare_off_i | input | 1 | Exclude the spare area from sequential reads |
| wp_ni | input | 1 | Write protect, active low |
| stat_err_i | input | 1 | Error flag for the status word |
| stat_plane_i | input | 4 | Plane flags for the status word |
| arr_col_o | output | PAGE_W+2 | Column presented to the array read port |
| arr_data_i | input | 8*BUS_BYTES | Array word at `arr_col_o` |
| rdata_o | output | 8*BUS_BYTES | Registered read data |
| rb_o | output | 1 | Ready/busy, 1 = ready |

## Verification
Every strobe result appears on `rdata_o` one clock after the edge that samples `re_i`. `arr_col_o` is combinational, so it already reflects a reload in the cycle the strobe is presented. The bench drives inputs just after each falling edge and updates a behavioural model at each rising edge. At the next falling edge it compares `rdata_o`, `rb_o` and `arr_col_o` with the model. Each comparison therefore sees exactly the edge that produced it. The model computes the expected column from its own state and the inputs still applied, so reload and clamping cycles are checked at the port too.

// File: rtl/nand_rd_pkg.sv
package nand_rd_pkg;

  typedef enum logic [1:0] {
    MODE_READ   = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_ID     = 2'd2
  } rd_mode_e;

  localparam int unsigned ID_LEN = 4;

  function automatic logic [7:0] status_byte(input logic wp_n, input logic err,
                                             input logic [3:0] plane);
    return {wp_n, 1'b1, 1'b0, plane, err};
  endfunction

endpackage

// File: rtl/nand_rd_seq.sv
module nand_rd_seq #(
  parameter int unsigned PAGE_W    = 11,
  parameter int unsigned BUS_BYTES = 1,
  localparam int unsigned COL_W    = PAGE_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] ofs_i,
  input  logic             strobe_i,
  input  logic             spare_off_i,
  input  logic             ce_ni,
  output logic [COL_W-1:0] col_o,
  output logic             take_o
);

  localparam int unsigned PAGE_B  = 1 << PAGE_W;
  localparam int unsigned SPARE_B = PAGE_B >> 5;
  localparam int unsigned FULL_B  = PAGE_B + SPARE_B;
  localparam logic [COL_W:0] PAGE_L = (COL_W+1)'(PAGE_B);
  localparam logic [COL_W:0] FULL_L = (COL_W+1)'(FULL_B);
  localparam logic [COL_W:0] STEP_L = (COL_W+1)'(BUS_BYTES);

  logic [COL_W-1:0] col_q, ofs_q, rem_q;
  logic [COL_W:0]   start_c, limit_c, load_len, eff_col, eff_len, nxt_len, adv_col;
  logic             load;

  always_comb begin
    limit_c  = spare_off_i ? PAGE_L : FULL_L;
    start_c  = {1'b0, col_q} + {1'b0, ofs_q};
    load     = strobe_i && (rem_q == '0);
    load_len = (start_c >= limit_c) ? '0 : (limit_c - start_c);
    eff_col  = load ? ((start_c > limit_c) ? limit_c : start_c) : {1'b0, col_q};
    eff_len  = load ? load_len : {1'b0, rem_q};
    take_o   = strobe_i && !ce_ni && (eff_len != '0);
    nxt_len  = (eff_len > STEP_L) ? (eff_len - STEP_L) : '0;
    adv_col  = eff_col + STEP_L;
  end

  assign col_o = eff_col[COL_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      ofs_q <= '0;
      rem_q <= '0;
    end else if (start_i) begin
      col_q <= col_i;
      ofs_q <= ofs_i;
      rem_q <= '0;
    end else if (strobe_i) begin
      if (load) ofs_q <= '0;
      if (take_o) begin
        col_q <= adv_col[COL_W-1:0];
        rem_q <= nxt_len[COL_W-1:0];
      end else begin
        col_q <= eff_col[COL_W-1:0];
        rem_q <= eff_len[COL_W-1:0];
      end
    end
  end

  AST_REM_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, rem_q} <= FULL_L); // R7
  AST_REM_SHRINK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && !start_i) |=> ({1'b0, rem_q} < $past(eff_len))); // R9
  AST_OFS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load && !start_i) |=> (ofs_q == '0)); // R6

endmodule

// File: rtl/nand_rd_id.sv
module nand_rd_id #(
  parameter logic [7:0]  MAKER_CODE = 8'h2C,
  parameter logic [7:0]  PART_CODE  = 8'hDA,
  parameter logic [7:0]  FILL_CODE  = 8'hA5,
  parameter bit          LARGE_PAGE = 1'b1,
  parameter int unsigned BUS_BYTES  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       strobe_i,
  input  logic       ce_ni,
  output logic [7:0] byte_o,
  output logic       take_o
);
  import nand_rd_pkg::*;

  localparam logic [7:0] TAIL_CODE = LARGE_PAGE ? ((BUS_BYTES == 2) ? 8'h55 : 8'h15) : 8'hC0;
  localparam logic [2:0] LAST_IDX  = 3'(ID_LEN);

  logic [2:0] idx_q;

  always_comb begin
    take_o = strobe_i && !ce_ni && (idx_q < LAST_IDX);
    unique case (idx_q[1:0])
      2'd0:    byte_o = MAKER_CODE;
      2'd1:    byte_o = PART_CODE;
      2'd2:    byte_o = FILL_CODE;
      default: byte_o = TAIL_CODE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (start_i) idx_q <= '0;
    else if (take_o)  idx_q <= idx_q + 3'd1;
  end

  AST_ID_IDX_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_q <= LAST_IDX); // R4
  AST_ID_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idx_q == LAST_IDX && !start_i) |=> (idx_q == LAST_IDX)); // R4

endmodule

// File: rtl/nand_rd_path.sv
module nand_rd_path #(
  parameter int unsigned PAGE_W     = 11,
  parameter int unsigned BUS_BYTES  = 1,
  parameter bit          LARGE_PAGE = 1'b1,
  parameter logic [7:0]  MAKER_CODE = 8'h2C,
  parameter logic [7:0]  PART_CODE  = 8'hDA,
  parameter logic [7:0]  FILL_CODE  = 8'hA5,
  localparam int unsigned COL_W     = PAGE_W + 2,
  localparam int unsigned DW        = 8 * BUS_BYTES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_read_i,
  input  logic             cmd_status_i,
  input  logic             cmd_id_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [COL_W-1:0] ofs_i,
  input  logic             re_i,
  input  logic             ce_ni,
  input  logic             spare_off_i,
  input  logic             wp_ni,
  input  logic             stat_err_i,
  input  logic [3:0]       stat_plane_i,
  output logic [COL_W-1:0] arr_col_o,
  input  logic [DW-1:0]    arr_data_i,
  output logic [DW-1:0]    rdata_o,
  output logic             rb_o
);
  import nand_rd_pkg::*;

  rd_mode_e      mode_q;
  logic          cmd_any, re_eff;
  logic          seq_take, id_take;
  logic [7:0]    id_byte;
  logic [DW-1:0] stat_word, id_word, rdata_d;

  assign cmd_any = cmd_read_i | cmd_status_i | cmd_id_i;
  assign re_eff  = re_i & ~cmd_any;
  assign rb_o    = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           mode_q <= MODE_READ;
    else if (cmd_status_i) mode_q <= MODE_STATUS;
    else if (cmd_id_i)     mode_q <= MODE_ID;
    else if (cmd_read_i)   mode_q <= MODE_READ;
  end

  nand_rd_seq #(
    .PAGE_W   (PAGE_W),
    .BUS_BYTES(BUS_BYTES)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (cmd_read_i & ~cmd_status_i & ~cmd_id_i),
    .col_i      (col_i),
    .ofs_i      (ofs_i),
    .strobe_i   (re_eff && (mode_q == MODE_READ)),
    .spare_off_i(spare_off_i),
    .ce_ni      (ce_ni),
    .col_o      (arr_col_o),
    .take_o     (seq_take)
  );

  nand_rd_id #(
    .MAKER_CODE(MAKER_CODE),
    .PART_CODE (PART_CODE),
    .FILL_CODE (FILL_CODE),
    .LARGE_PAGE(LARGE_PAGE),
    .BUS_BYTES (BUS_BYTES)
  ) u_id (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (cmd_id_i & ~cmd_status_i),
    .strobe_i(re_eff && (mode_q == MODE_ID)),
    .ce_ni   (ce_ni),
    .byte_o  (id_byte),
    .take_o  (id_take)
  );

  // byte-wide sources sit in lane 0, upper lanes stay zero
  always_comb begin
    stat_word      = '0;
    stat_word[7:0] = status_byte(wp_ni, stat_err_i, stat_plane_i);
    id_word        = '0;
    id_word[7:0]   = id_byte;
    rdata_d        = '0;
    if (!ce_ni) begin
      unique case (mode_q)
        MODE_READ:   rdata_d = seq_take ? arr_data_i : '0;
        MODE_STATUS: rdata_d = stat_word;
        MODE_ID:     rdata_d = id_take ? id_word : '0;
        default:     rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (re_eff) rdata_o <= rdata_d;
  end

  AST_CE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && ce_ni && !cmd_any) |=> (rdata_o == '0)); // R8
  AST_STATUS_COL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STATUS && re_i && !cmd_any) |=> $stable(arr_col_o)); // R3
  AST_STATUS_WP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_STATUS && re_i && !ce_ni && !cmd_any) |=> (rdata_o[7] == $past(wp_ni))); // R2
  AST_DATA_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_READ && re_i && !ce_ni && !cmd_any && seq_take) |=> (rdata_o == $past(arr_data_i))); // R10
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!re_i) |=> $stable(rdata_o)); // R10

  if (BUS_BYTES > 1) begin : g_pad_chk
    AST_PAD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_q != MODE_READ && re_i && !cmd_any) |=> (rdata_o[DW-1:8] == '0)); // R5
  end

endmodule

// File: tb/nand_rd_path_tb.sv
`timescale 1ns/1ps
module nand_rd_path_tb;

  localparam int PW    = 6;
  localparam int BUS   = 2;
  localparam int CW    = PW + 2;
  localparam int DW    = 8 * BUS;
  localparam int PAGE  = 1 << PW;
  localparam int FULL  = PAGE + (PAGE >> 5);
  localparam logic [7:0] MK = 8'h2C, PT = 8'hDA, FL = 8'hA5, TL = 8'h55;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_read = 0, cmd_status = 0, cmd_id = 0;
  logic [CW-1:0] col_in = '0, ofs_in = '0;
  logic re = 0, ce_n = 0, spare_off = 0, wp_n = 1, st_err = 0;
  logic [3:0] st_plane = '0;
  logic [CW-1:0] arr_col;
  logic [DW-1:0] arr_data, rdata;
  logic rb;

  always #10 clk = ~clk;

  function automatic logic [15:0] pat(input int c);
    logic [7:0] b;
    b = 8'(c);
    return {b ^ 8'hC3, b + 8'h20};
  endfunction

  assign arr_data = pat(int'(arr_col));

  nand_rd_path #(
    .PAGE_W(PW), .BUS_BYTES(BUS), .LARGE_PAGE(1'b1),
    .MAKER_CODE(MK), .PART_CODE(PT), .FILL_CODE(FL)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_read_i(cmd_read), .cmd_status_i(cmd_status), .cmd_id_i(cmd_id),
    .col_i(col_in), .ofs_i(ofs_in), .re_i(re), .ce_ni(ce_n),
    .spare_off_i(spare_off), .wp_ni(wp_n), .stat_err_i(st_err), .stat_plane_i(st_plane),
    .arr_col_o(arr_col), .arr_data_i(arr_data), .rdata_o(rdata), .rb_o(rb)
  );

  // behavioural reference
  int m_mode = 0, m_col = 0, m_ofs = 0, m_rem = 0, m_idx = 0;
  logic [DW-1:0] m_rd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_col = 0; m_ofs = 0; m_rem = 0; m_idx = 0; m_rd = '0;
    end else if (cmd_status) begin
      m_mode = 1;
    end else if (cmd_id) begin
      m_mode = 2; m_idx = 0;
    end else if (cmd_read) begin
      m_mode = 0; m_col = int'(col_in); m_ofs = int'(ofs_in); m_rem = 0;
    end else if (re) begin
      if (m_mode == 0) begin
        int c, len, lim, st;
        lim = spare_off ? PAGE : FULL;
        if (m_rem == 0) begin
          st = m_col + m_ofs;
          m_ofs = 0;
          len = (st >= lim) ? 0 : lim - st;
          c = (st > lim) ? lim : st;
        end else begin
          c = m_col; len = m_rem;
        end
        if (!ce_n && len > 0) begin
          m_rd = pat(c);
          m_col = c + BUS;
          m_rem = (len > BUS) ? len - BUS : 0;
        end else begin
          m_rd = '0; m_col = c; m_rem = len;
        end
      end else if (m_mode == 1) begin
        m_rd = ce_n ? '0 : {8'h00, wp_n, 1'b1, 1'b0, st_plane, st_err};
      end else begin
        if (!ce_n && m_idx < 4) begin
          case (m_idx)
            0: m_rd = {8'h00, MK};
            1: m_rd = {8'h00, PT};
            2: m_rd = {8'h00, FL};
            default: m_rd = {8'h00, TL};
          endcase
          m_idx++;
        end else m_rd = '0;
      end
    end
  end

  int vectors = 0, errors = 0, cycles = 0;
  string cur_req = "R1";

  function automatic int exp_col();
    int st, lim;
    if (m_mode == 0 && re && !(cmd_read | cmd_status | cmd_id) && m_rem == 0) begin
      lim = spare_off ? PAGE : FULL;
      st = m_col + m_ofs;
      return (st > lim) ? lim : st;
    end
    return m_col;
  endfunction

  task automatic compare();
    bit bad;
    int ec;
    bad = 0;
    ec = exp_col();
    vectors++;
    if (rdata !== m_rd) begin
      bad = 1;
      $display("FAIL %s rdata_o act %h exp %h at %0t", cur_req, rdata, m_rd, $time);
    end
    if (rb !== 1'b1) begin
      bad = 1;
      $display("FAIL R1 rb_o act %b exp 1 at %0t", rb, $time);
    end
    if (int'(arr_col) != ec) begin
      bad = 1;
      $display("FAIL %s arr_col_o act %0d exp %0d at %0t", cur_req, arr_col, ec, $time);
    end
    if (bad) errors++;
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic issue_read(input int c, input int o);
    tick(); re = 0; cmd_read = 1; col_in = CW'(c); ofs_in = CW'(o);
    tick(); cmd_read = 0;
  endtask

  task automatic issue_status();
    tick(); re = 0; cmd_status = 1;
    tick(); cmd_status = 0;
  endtask

  task automatic issue_id();
    tick(); re = 0; cmd_id = 1;
    tick(); cmd_id = 0;
  endtask

  task automatic burst(input int n);
    for (int i = 0; i < n; i++) begin
      tick(); re = 1;
    end
    tick(); re = 0;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) tick();
    rst_n = 1;
    tick();
    tick();
    // R6 R10: first load from column 0, back-to-back words
    cur_req = "R6";
    issue_read(0, 0);
    burst(10);
    // R9: continue stepping through page and spare
    cur_req = "R9";
    burst(23);
    // R7: page plus spare exhausted, reload yields nothing
    cur_req = "R7";
    burst(3);
    // R7: spare disabled, start column 10
    spare_off = 1;
    issue_read(10, 0);
    burst(30);
    // R6: reload after exhaust picks up spare once enabled
    cur_req = "R6";
    spare_off = 0;
    burst(2);
    // R6: pending offset added to column, then cleared
    issue_read(4, 32);
    burst(3);
    // R10: gaps between strobes hold the bus
    cur_req = "R10";
    tick(); tick();
    burst(1);
    tick();
    // R8: chip enable high
    cur_req = "R8";
    ce_n = 1;
    burst(2);
    ce_n = 0;
    burst(2);
    issue_read(2, 0);
    ce_n = 1;
    burst(1);
    ce_n = 0;
    burst(2);
    // R7: odd start on a 2-byte bus, and clamp beyond limit
    cur_req = "R7";
    issue_read(61, 0);
    burst(5);
    issue_read(60, 40);
    burst(2);
    // R2 R3: status repeats, pointer frozen
    cur_req = "R2 R3";
    issue_status();
    st_plane = 4'b1010; st_err = 1;
    burst(3);
    wp_n = 0;
    burst(2);
    wp_n = 1; st_plane = 4'b0101; st_err = 0;
    burst(2);
    cur_req = "R8";
    ce_n = 1;
    burst(1);
    ce_n = 0;
    // R4 R5: ID sequence with zero upper lane
    cur_req = "R4 R5";
    issue_id();
    burst(6);
    // R11: a command ends status mode; strobe with command ignored
    cur_req = "R11";
    issue_status();
    burst(2);
    tick(); cmd_read = 1; col_in = CW'(8); ofs_in = '0; re = 1;
    tick(); cmd_read = 0; re = 0;
    burst(3);
    tick();
    finish_run();
  end

endmodule